// File: doc/BRIEF.md
# Chained Two-Stage Channel Trigger

This block lets one DMA channel start another without software. Each channel gets a role and a completion level. The role says whether the channel takes part in chaining, and if so whether it is a source or a destination in one of two independent groups. The completion level picks which done event of a source channel counts: fragment, block, transaction or list.

When a source channel raises its selected done pulse, the single destination channel of the same group receives a one-cycle start pulse on the next cycle. A group that has an armed source but does not have exactly one destination is flagged as misconfigured, and it issues no start.

The channels themselves are outside the block. They appear only as done pulses coming in and start pulses going out. Roles and levels are written through a narrow register write port. Data movement, bus access and arbitration are not part of this block.

Top module: `chain_trigger`

## Requirements
- R1: After reset every `start_o` bit and both `cfg_err` bits are 0, and every channel has role NONE and level NONE, so done pulses have no effect.
- R2: A role write (`cfg_sel`=0) uses the codes 0 NONE, 1 source of group 0, 2 source of group 1, 3 destination of group 0 and 4 destination of group 1. Codes 5 to 7 act as NONE.
- R3: A level write (`cfg_sel`=1) uses the codes 0 NONE, 1 fragment, 2 block, 3 transaction and 4 list. Only the done input of the selected level counts for a source channel. Done pulses at other levels are ignored.
- R4: A start pulse appears on the clock edge after the qualifying done pulse and lasts exactly one cycle.
- R5: A qualifying event on a source of group g starts only the one destination of group g. The other group's channels are not started.
- R6: A source channel whose level is NONE, or any code from 5 to 7, never causes a start and never arms its group.
- R7: If a group has an armed source (a source role with a level from 1 to 4) and its number of destinations is not exactly one, `cfg_err[g]` reads 1 and the group issues no start. Otherwise `cfg_err[g]` reads 0. The flag follows a configuration write by two cycles.
- R8: A done pulse on a channel whose role is NONE, or a destination role, issues no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_sel | input | 1 | 0 writes the role, 1 writes the level |
| cfg_data | input | 3 | Code written |
| done_frag | input | NUM_CH | Fragment-done pulse per channel |
| done_blk | input | NUM_CH | Block-done pulse per channel |
| done_trans | input | NUM_CH | Transaction-done pulse per channel |
| done_list | input | NUM_CH | List-done pulse per channel |
| start_o | output | NUM_CH | One-cycle start pulse per channel |
| cfg_err | output | 2 | Misconfiguration flag per group |

## Verification
A start is due one cycle after its done pulse. The bench drives each done pulse for one cycle from a falling edge and compares `start_o` at the next falling edge. It then checks `start_o` again one edge later, which confirms the pulse is one cycle wide. `cfg_err` passes through two registers after a write: the configuration register and then the flag register. So the bench waits two full cycles after its last write before comparing the flag. The sweep covers every role combination of four channels with varied levels, and the expected vectors come from a group-by-group count in the bench.

// File: rtl/chain_pkg.sv
package chain_pkg;
  typedef enum logic [2:0] {
    ROLE_NONE = 3'd0, ROLE_SRC0 = 3'd1, ROLE_SRC1 = 3'd2,
    ROLE_DST0 = 3'd3, ROLE_DST1 = 3'd4
  } role_e;

  typedef enum logic [2:0] {
    LVL_NONE = 3'd0, LVL_FRAG = 3'd1, LVL_BLOCK = 3'd2,
    LVL_TRANS = 3'd3, LVL_LIST = 3'd4
  } level_e;

  localparam int GROUPS = 2;

  // done_vec bit order: [0] frag, [1] block, [2] trans, [3] list
  function automatic logic pick_event(input logic [2:0] lvl, input logic [3:0] done_vec);
    case (lvl)
      LVL_FRAG:  pick_event = done_vec[0];
      LVL_BLOCK: pick_event = done_vec[1];
      LVL_TRANS: pick_event = done_vec[2];
      LVL_LIST:  pick_event = done_vec[3];
      default:   pick_event = 1'b0;
    endcase
  endfunction

  function automatic logic level_armed(input logic [2:0] lvl);
    level_armed = (lvl >= 3'd1) && (lvl <= 3'd4);
  endfunction

  function automatic logic is_src(input logic [2:0] role, input int grp);
    is_src = (role == 3'(1 + grp));
  endfunction

  function automatic logic is_dst(input logic [2:0] role, input int grp);
    is_dst = (role == 3'(3 + grp));
  endfunction
endpackage

// File: rtl/chain_mode_regs.sv
module chain_mode_regs #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CH_W-1:0]         cfg_ch,
  input  logic                    cfg_sel,
  input  logic [2:0]              cfg_data,
  output logic [NUM_CH-1:0][2:0]  role_q,
  output logic [NUM_CH-1:0][2:0]  lvl_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = cfg_we && (cfg_ch == CH_W'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        role_q[c] <= 3'd0;
        lvl_q[c]  <= 3'd0;
      end else if (hit) begin
        if (cfg_sel) lvl_q[c]  <= cfg_data;
        else         role_q[c] <= cfg_data;
      end
    end
  end
endmodule

// File: rtl/chain_evt_sel.sv
module chain_evt_sel #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0][2:0] lvl_q,
  input  logic [NUM_CH-1:0]      done_frag,
  input  logic [NUM_CH-1:0]      done_blk,
  input  logic [NUM_CH-1:0]      done_trans,
  input  logic [NUM_CH-1:0]      done_list,
  output logic [NUM_CH-1:0]      ch_evt
);
  import chain_pkg::*;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign ch_evt[c] = pick_event(lvl_q[c],
                         {done_list[c], done_trans[c], done_blk[c], done_frag[c]});
  end
endmodule

// File: rtl/chain_group_route.sv
module chain_group_route #(
  parameter int NUM_CH = 4,
  parameter int GRP    = 0,
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic [NUM_CH-1:0][2:0] role_q,
  input  logic [NUM_CH-1:0][2:0] lvl_q,
  input  logic [NUM_CH-1:0]      ch_evt,
  output logic                   fire,
  output logic                   armed,
  output logic                   dst_ok,
  output logic [NUM_CH-1:0]      dst_vec
);
  import chain_pkg::*;
  logic [CNT_W-1:0] dst_cnt;

  always_comb begin
    fire    = 1'b0;
    armed   = 1'b0;
    dst_vec = '0;
    dst_cnt = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (is_src(role_q[c], GRP) && level_armed(lvl_q[c])) begin
        armed = 1'b1;
        if (ch_evt[c]) fire = 1'b1;
      end
      if (is_dst(role_q[c], GRP)) begin
        dst_vec[c] = 1'b1;
        dst_cnt    = dst_cnt + 1'b1;
      end
    end
  end

  assign dst_ok = (dst_cnt == CNT_W'(1));
endmodule

// File: rtl/chain_trigger.sv
module chain_trigger #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic              cfg_sel,
  input  logic [2:0]        cfg_data,
  input  logic [NUM_CH-1:0] done_frag,
  input  logic [NUM_CH-1:0] done_blk,
  input  logic [NUM_CH-1:0] done_trans,
  input  logic [NUM_CH-1:0] done_list,
  output logic [NUM_CH-1:0] start_o,
  output logic [1:0]        cfg_err
);
  import chain_pkg::*;

  logic [NUM_CH-1:0][2:0] role_q;
  logic [NUM_CH-1:0][2:0] lvl_q;
  logic [NUM_CH-1:0]      ch_evt;
  logic [GROUPS-1:0]      grp_fire;
  logic [GROUPS-1:0]      grp_armed;
  logic [GROUPS-1:0]      grp_dst_ok;
  logic [NUM_CH-1:0]      grp_dst [GROUPS];
  logic [NUM_CH-1:0]      start_d;

  chain_mode_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .role_q(role_q), .lvl_q(lvl_q)
  );

  chain_evt_sel #(.NUM_CH(NUM_CH)) u_sel (
    .lvl_q(lvl_q), .done_frag(done_frag), .done_blk(done_blk),
    .done_trans(done_trans), .done_list(done_list), .ch_evt(ch_evt)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    chain_group_route #(.NUM_CH(NUM_CH), .GRP(g)) u_route (
      .role_q(role_q), .lvl_q(lvl_q), .ch_evt(ch_evt),
      .fire(grp_fire[g]), .armed(grp_armed[g]),
      .dst_ok(grp_dst_ok[g]), .dst_vec(grp_dst[g])
    );
  end

  always_comb begin
    start_d = '0;
    for (int g = 0; g < GROUPS; g++)
      if (grp_fire[g] && grp_dst_ok[g]) start_d = start_d | grp_dst[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= '0;
      cfg_err <= '0;
    end else begin
      start_o <= start_d;
      cfg_err <= grp_armed & ~grp_dst_ok;
    end
  end
endmodule

// File: rtl/chain_trigger_chk.sv
module chain_trigger_chk #(
  parameter int NUM_CH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CH-1:0][2:0] role_q,
  input logic [1:0]             grp_fire,
  input logic [1:0]             grp_armed,
  input logic [1:0]             grp_dst_ok,
  input logic [NUM_CH-1:0]      start_o
);
  // R4: a start only follows a cycle in which some group fired
  a_r4_start_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_o) |-> $past(|grp_fire));

  // R7: no group both fired and had a lone destination -> nothing starts
  a_r7_no_start_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!(grp_fire[0] && grp_dst_ok[0]) && !(grp_fire[1] && grp_dst_ok[1]))
      |=> (start_o == '0));

  for (genvar g = 0; g < 2; g++) begin : g_a
    // R6: firing requires an armed source
    a_r6_fire_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
      grp_fire[g] |-> grp_armed[g]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R5, R8: only a destination-role channel is started
    a_r5_start_hits_dst: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[c] |-> ($past(role_q[c]) == 3'd3 || $past(role_q[c]) == 3'd4));
  end
endmodule

bind chain_trigger chain_trigger_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .role_q(role_q), .grp_fire(grp_fire),
  .grp_armed(grp_armed), .grp_dst_ok(grp_dst_ok), .start_o(start_o)
);

// File: tb/chain_trigger_test.sv
module chain_trigger_test;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [1:0] cfg_ch = 0;
  logic [2:0] cfg_data = 0;
  logic [N-1:0] done_frag = 0, done_blk = 0, done_trans = 0, done_list = 0;
  logic [N-1:0] start_o;
  logic [1:0] cfg_err;
  int tests = 0, fails = 0;
  int bm [N], bt [N];
  bit finished = 0;

  always #10 clk = ~clk;

  chain_trigger #(.NUM_CH(N)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .done_frag(done_frag),
    .done_blk(done_blk), .done_trans(done_trans), .done_list(done_list),
    .start_o(start_o), .cfg_err(cfg_err)
  );

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, int sel, int data);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_sel = sel[0]; cfg_data = 3'(data);
    if (sel == 0) bm[ch] = data; else bt[ch] = data;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic int dst_count(int g);
    int n = 0;
    for (int c = 0; c < N; c++) if (bm[c] == 3 + g) n++;
    return n;
  endfunction

  function automatic int exp_err();
    int e = 0;
    for (int g = 0; g < 2; g++) begin
      bit arm = 0;
      for (int c = 0; c < N; c++)
        if (bm[c] == 1 + g && bt[c] >= 1 && bt[c] <= 4) arm = 1;
      if (arm && dst_count(g) != 1) e |= (1 << g);
    end
    return e;
  endfunction

  function automatic int exp_start(int lv, int mask);
    int s = 0;
    for (int g = 0; g < 2; g++) begin
      bit f = 0;
      for (int c = 0; c < N; c++)
        if (mask[c] && bm[c] == 1 + g && bt[c] == lv + 1) f = 1;
      if (f && dst_count(g) == 1)
        for (int c = 0; c < N; c++) if (bm[c] == 3 + g) s |= (1 << c);
    end
    return s;
  endfunction

  // lv: 0 frag, 1 block, 2 trans, 3 list
  task automatic pulse(string tag, int lv, int mask);
    @(negedge clk);
    done_frag  = (lv == 0) ? N'(mask) : '0;
    done_blk   = (lv == 1) ? N'(mask) : '0;
    done_trans = (lv == 2) ? N'(mask) : '0;
    done_list  = (lv == 3) ? N'(mask) : '0;
    @(negedge clk);
    done_frag = 0; done_blk = 0; done_trans = 0; done_list = 0;
    check(tag, start_o, exp_start(lv, mask));
    @(negedge clk);
    check("R4 pulse width", start_o, 0);
  endtask

  task automatic settle_err(string tag);
    @(negedge clk); @(negedge clk);
    check(tag, cfg_err, exp_err());
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < N; c++) begin bm[c] = 0; bt[c] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset start", start_o, 0);
    check("R1 reset err", cfg_err, 0);
    rst_n = 1;
    for (int lv = 0; lv < 4; lv++) pulse("R1 unconfigured", lv, 4'hF);

    // R2: role code 5 behaves as NONE; R3: level selection
    wr(0, 0, 1); wr(0, 1, 1); wr(1, 0, 3);
    settle_err("R2 legal pair err");
    for (int lv = 0; lv < 4; lv++) pulse("R3 frag only", lv, 4'b0001);
    check("R3 frag starts ch1", exp_start(0, 1), 4'b0010);
    wr(0, 0, 5);
    settle_err("R2 code5 err");
    pulse("R2 code5 ignored", 0, 4'b0001);

    // R6: source with level NONE or illegal level
    wr(0, 0, 1); wr(0, 1, 0);
    settle_err("R6 none level err");
    for (int lv = 0; lv < 4; lv++) pulse("R6 level none", lv, 4'hF);
    wr(0, 1, 6);
    settle_err("R6 level6 err");
    pulse("R6 level6", 0, 4'hF);

    // R8: destination and NONE channels' done ignored
    wr(0, 1, 2);
    pulse("R8 dst done ignored", 1, 4'b1110);
    pulse("R5 block start", 1, 4'b0001);

    // R5: group independence
    wr(2, 0, 2); wr(2, 1, 4); wr(3, 0, 4);
    settle_err("R5 two groups err");
    pulse("R5 group1 only", 3, 4'b0100);
    pulse("R5 group0 only", 1, 4'b0001);

    // R7: two destinations in group 0
    wr(3, 0, 3);
    settle_err("R7 two dst err");
    pulse("R7 blocked", 1, 4'b0001);
    pulse("R7 group1 blocked no dst", 3, 4'b0100);

    // Sweep of every role combination
    for (int m = 0; m < 625; m++) begin
      int r = m;
      for (int c = 0; c < N; c++) begin
        wr(c, 0, r % 5); r = r / 5;
        wr(c, 1, (m + 3 * c) % 6);
      end
      settle_err("R7 sweep err");
      for (int lv = 0; lv < 4; lv++) pulse("R3/R5 sweep start", lv, 4'hF);
      pulse("R5 sweep partial", m % 4, 4'b0101);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule